// File: doc/BRIEF.md
# Vector Element Insert Unit

This unit executes one family of vector-insert instructions. It takes a 32-bit instruction word, the current 128-bit contents of the destination vector, a 64-bit source value and a 64-bit index operand. It writes the low-order 1, 2, 4 or 8 bytes of the source into the vector at a byte position taken from the index operand. The position is counted either from the most significant end of the vector (left mode) or from the least significant end (right mode). Bytes outside the written element are kept.

The unit decodes eight instruction variants: four element sizes, each in a left form and a right form. An unrecognised instruction raises an illegal flag and leaves the vector as it was. A position that leaves the element wholly or partly outside the vector raises a range flag, and again nothing is written.

While an instruction is presented, the two source-register numbers are shown combinationally so that the register file can supply the operands. All results are registered and appear one cycle after the valid strobe.

Top module: `vec_insert_unit`

## Requirements
- R1: An instruction is legal only when bits [31:26] are 000100, bits [10:9] are 01 and bits [5:0] are 001111. For a legal instruction, bit [8] selects right mode (1) or left mode (0), and bits [7:6] select the element size as 1 << value bytes (00 byte, 01 halfword, 10 word, 11 doubleword).
- R2: `upd_valid`, `range_err` and `illegal` are each high only in the cycle after a cycle with `in_valid` high. `vec_out` and `dst_reg` change only in that cycle.
- R3: The raw index is `idx_op[3:0]`. Bits [63:4] of `idx_op` have no effect.
- R4: Vector bytes are numbered 0 to 15, with byte 0 at bits [127:120]. In left mode the raw index is the byte number of the element's most significant byte.
- R5: In right mode the effective index is (16 − size) − raw index, computed as a signed value.
- R6: The inserted element is the least significant size bytes of `src_val`, most significant byte first.
- R7: On an update, every vector byte outside the element equals the corresponding byte of `vec_in`.
- R8: If the effective index is negative or greater than 16 − size, `vec_out` equals `vec_in`, `upd_valid` stays low and `range_err` is high for exactly that one result cycle.
- R9: An illegal instruction with `in_valid` high gives `illegal` high for one cycle and `vec_out` equal to `vec_in`. Flags `upd_valid`, `range_err` and `illegal` are never high together.
- R10: `dst_reg` is registered from instruction bits [25:21]. `idx_reg_sel` shows bits [20:16] and `val_reg_sel` shows bits [15:11], both combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| vec_in | input | 128 | Current destination vector contents |
| src_val | input | 64 | Value operand |
| idx_op | input | 64 | Index operand |
| idx_reg_sel | output | 5 | Register number of the index operand |
| val_reg_sel | output | 5 | Register number of the value operand |
| vec_out | output | 128 | Resulting vector, registered |
| dst_reg | output | 5 | Destination register number, registered |
| upd_valid | output | 1 | Result pulse: vector updated |
| range_err | output | 1 | Result pulse: position out of range, no write |
| illegal | output | 1 | Result pulse: unrecognised instruction, no write |

## Verification
The register selects are due in the same cycle the instruction is driven. The bench checks them a short delay after driving, before the next clock edge. The vector, the destination number and the three flags are due one edge after the strobe. The bench drives on the falling edge and compares with its model on the next falling edge, after exactly one rising edge. It also checks in idle cycles that no flag pulses and the vector holds.

// File: rtl/vi_pkg.sv
package vi_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } elem_sz_e;

  typedef struct packed {
    logic       legal;
    logic       right;
    elem_sz_e   sz;
    logic [4:0] vt;
    logic [4:0] va;
    logic [4:0] vb;
  } vi_dec_t;

  localparam logic [5:0] PRIMARY_OP = 6'b000100;
  localparam logic [1:0] XO_HEAD    = 2'b01;
  localparam logic [5:0] XO_TAIL    = 6'b001111;

endpackage

// File: rtl/vi_decode.sv
module vi_decode
  import vi_pkg::*;
(
  input  logic [31:0] instr,
  output vi_dec_t     dec
);
  logic op_hit;
  logic xo_hit;

  assign op_hit = (instr[31:26] == PRIMARY_OP);
  assign xo_hit = (instr[10:9] == XO_HEAD) && (instr[5:0] == XO_TAIL);

  always_comb begin
    dec.legal = op_hit && xo_hit;
    dec.right = instr[8];
    dec.sz    = elem_sz_e'(instr[7:6]);
    dec.vt    = instr[25:21];
    dec.va    = instr[20:16];
    dec.vb    = instr[15:11];
  end
endmodule

// File: rtl/vi_index.sv
module vi_index #(
  parameter int VEC_BYTES = 16,
  localparam int RAWW = $clog2(VEC_BYTES),
  localparam int EW   = RAWW + 2
) (
  input  logic                  right,
  input  logic [RAWW-1:0]       raw,
  input  logic [RAWW:0]         size_n,
  output logic signed [EW-1:0]  eff,
  output logic [RAWW-1:0]       start,
  output logic                  ok
);
  function automatic logic signed [EW-1:0] limit_of(logic [RAWW:0] sz);
    logic signed [EW-1:0] lim;
    lim = EW'(VEC_BYTES) - EW'(sz);
    return lim;
  endfunction

  function automatic logic signed [EW-1:0] effective(logic r, logic [RAWW-1:0] rw,
                                                     logic [RAWW:0] sz);
    logic signed [EW-1:0] lim;
    lim = limit_of(sz);
    return r ? (lim - EW'(rw)) : EW'(rw);
  endfunction

  function automatic logic fits(logic signed [EW-1:0] e, logic [RAWW:0] sz);
    logic signed [EW-1:0] lim;
    lim = limit_of(sz);
    return !e[EW-1] && (e <= lim);
  endfunction

  assign eff   = effective(right, raw, size_n);
  assign ok    = fits(eff, size_n);
  assign start = eff[RAWW-1:0];
endmodule

// File: rtl/vi_merge.sv
module vi_merge #(
  parameter int VEC_BYTES = 16,
  parameter int SRC_BYTES = 8,
  localparam int RAWW = $clog2(VEC_BYTES),
  localparam int SRCW = $clog2(SRC_BYTES)
) (
  input  logic [8*VEC_BYTES-1:0] vec_in,
  input  logic [8*SRC_BYTES-1:0] src,
  input  logic [RAWW-1:0]        start,
  input  logic [RAWW:0]          size_n,
  input  logic                   en,
  output logic [8*VEC_BYTES-1:0] vec_out,
  output logic [VEC_BYTES-1:0]   byte_hit
);
  function automatic logic [7:0] src_byte(logic [8*SRC_BYTES-1:0] s, logic [SRCW-1:0] j);
    return s[8*j +: 8];
  endfunction

  logic [RAWW:0] lo;
  logic [RAWW:0] hi;
  assign lo = {1'b0, start};
  assign hi = lo + size_n;

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    localparam logic [RAWW:0] POS = (RAWW+1)'(b);
    logic [RAWW:0] rel;
    logic [SRCW-1:0] jsel;
    assign rel         = POS - lo;
    assign jsel        = SRCW'(size_n - 1'b1 - rel);
    assign byte_hit[b] = en && (POS >= lo) && (POS < hi);
    assign vec_out[8*(VEC_BYTES-1-b) +: 8] =
      byte_hit[b] ? src_byte(src, jsel) : vec_in[8*(VEC_BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit
  import vi_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int SRC_BYTES = 8,
  parameter int IDX_W     = 64,
  localparam int RAWW = $clog2(VEC_BYTES),
  localparam int EW   = RAWW + 2,
  localparam int VW   = 8 * VEC_BYTES,
  localparam int SW   = 8 * SRC_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [VW-1:0] vec_in,
  input  logic [SW-1:0] src_val,
  input  logic [IDX_W-1:0] idx_op,
  output logic [4:0]    idx_reg_sel,
  output logic [4:0]    val_reg_sel,
  output logic [VW-1:0] vec_out,
  output logic [4:0]    dst_reg,
  output logic          upd_valid,
  output logic          range_err,
  output logic          illegal
);
  vi_dec_t dec;
  logic [RAWW:0] size_n;
  logic signed [EW-1:0] eff;
  logic [RAWW-1:0] start;
  logic idx_ok;
  logic wr_go;
  logic rng_evt;
  logic ill_evt;
  logic [VW-1:0] merged;
  logic [VEC_BYTES-1:0] byte_hit;
  logic unused_idx_hi;

  assign unused_idx_hi = ^idx_op[IDX_W-1:RAWW];

  vi_decode u_dec (.instr(instr), .dec(dec));

  assign size_n      = (RAWW+1)'(1) << dec.sz;
  assign idx_reg_sel = dec.va;
  assign val_reg_sel = dec.vb;

  vi_index #(.VEC_BYTES(VEC_BYTES)) u_idx (
    .right (dec.right),
    .raw   (idx_op[RAWW-1:0]),
    .size_n(size_n),
    .eff   (eff),
    .start (start),
    .ok    (idx_ok)
  );

  assign wr_go   = in_valid && dec.legal && idx_ok;
  assign rng_evt = in_valid && dec.legal && !idx_ok;
  assign ill_evt = in_valid && !dec.legal;

  vi_merge #(.VEC_BYTES(VEC_BYTES), .SRC_BYTES(SRC_BYTES)) u_mrg (
    .vec_in  (vec_in),
    .src     (src_val),
    .start   (start),
    .size_n  (size_n),
    .en      (wr_go),
    .vec_out (merged),
    .byte_hit(byte_hit)
  );

  logic [VW-1:0] hit_bits;
  always_comb begin
    for (int i = 0; i < VEC_BYTES; i++) begin
      hit_bits[8*(VEC_BYTES-1-i) +: 8] = {8{byte_hit[i]}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      dst_reg   <= '0;
      upd_valid <= 1'b0;
      range_err <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      upd_valid <= wr_go;
      range_err <= rng_evt;
      illegal   <= ill_evt;
      if (in_valid) begin
        vec_out <= merged;
        dst_reg <= dec.vt;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_valid, range_err, illegal})); // R9
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid || range_err || illegal) |-> $past(in_valid)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(vec_out)); // R2
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (range_err || illegal) |-> (vec_out == $past(vec_in))); // R8
  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> ($countones(byte_hit) == int'(size_n))); // R6
  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |-> (byte_hit == '0)); // R8
  AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (((vec_out ^ $past(vec_in)) & ~$past(hit_bits)) == '0)); // R7
  AST_RIGHT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && dec.right) |-> (int'(start) + int'(idx_op[RAWW-1:0]) + int'(size_n) == VEC_BYTES)); // R5
endmodule

// File: tb/tb_vec_insert_unit.sv
`timescale 1ns/1ps
module tb_vec_insert_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [127:0] vec_in = '0;
  logic [63:0] src_val = '0;
  logic [63:0] idx_op = '0;
  logic [4:0] idx_reg_sel, val_reg_sel, dst_reg;
  logic [127:0] vec_out;
  logic upd_valid, range_err, illegal;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vec_insert_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .vec_in(vec_in), .src_val(src_val), .idx_op(idx_op),
    .idx_reg_sel(idx_reg_sel), .val_reg_sel(val_reg_sel),
    .vec_out(vec_out), .dst_reg(dst_reg),
    .upd_valid(upd_valid), .range_err(range_err), .illegal(illegal)
  );

  function automatic [31:0] mk(bit right, bit [1:0] sz, bit [4:0] t, bit [4:0] a, bit [4:0] b);
    return {6'b000100, t, a, b, 2'b01, right, sz, 6'b001111};
  endfunction

  // Behavioural reference: shift-and-mask over the whole vector.
  task automatic model(input [31:0] ins, input [127:0] v, input [63:0] s, input [63:0] ix,
                       output [127:0] ev, output bit upd, output bit rng, output bit ill);
    int sz, raw, eff, sh;
    logic [127:0] m;
    ill = !(ins[31:26] == 6'd4 && ins[10:9] == 2'b01 && ins[5:0] == 6'b001111);
    sz  = 1 << ins[7:6];
    raw = int'(ix[3:0]);
    eff = ins[8] ? (16 - sz) - raw : raw;
    rng = !ill && (eff < 0 || eff > 16 - sz);
    upd = !ill && !rng;
    ev  = v;
    if (upd) begin
      sh = 128 - 8 * (eff + sz);
      m  = ((128'd1 << (8 * sz)) - 128'd1);
      ev = (v & ~(m << sh)) | (({64'd0, s} & m) << sh);
    end
  endtask

  task automatic chk(input string tag, input [127:0] got, input [127:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drives at a falling edge, checks one falling edge later.
  task automatic apply(input [31:0] ins, input [127:0] v, input [63:0] s,
                       input [63:0] ix, input string tag);
    logic [127:0] ev;
    bit upd, rng, ill;
    model(ins, v, s, ix, ev, upd, rng, ill);
    instr = ins; vec_in = v; src_val = s; idx_op = ix; in_valid = 1'b1;
    #1;
    chk({tag, " R10 sel"}, {118'd0, idx_reg_sel, val_reg_sel}, {118'd0, ins[20:16], ins[15:11]});
    @(negedge clk);
    chk({tag, " vec"}, vec_out, ev);
    chk({tag, " R2 flags"}, {125'd0, upd_valid, range_err, illegal}, {125'd0, upd, rng, ill});
    chk({tag, " R10 dst"}, {123'd0, dst_reg}, {123'd0, ins[25:21]});
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    logic [127:0] held;
    held = vec_out;
    for (int i = 0; i < n; i++) begin
      instr = $urandom; vec_in = {4{$urandom}};
      @(negedge clk);
      chk("R2 idle flags", {125'd0, upd_valid, range_err, illegal}, 128'd0);
      chk("R2 idle hold", vec_out, held);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] base;
    base = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    repeat (3) @(negedge clk);
    chk("reset vec", vec_out, 128'd0);
    chk("reset flags", {125'd0, upd_valid, range_err, illegal}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 left byte at 0 lands at bits [127:120]; R6 low byte of source
    apply(mk(0, 2'd0, 5'd3, 5'd4, 5'd5), 128'd0, 64'h1122334455667788, 64'd0, "R4 left byte 0");
    chk("R4 literal", vec_out, {8'h88, 120'd0});
    apply(mk(0, 2'd0, 5'd1, 5'd2, 5'd3), base, 64'hAB, 64'd15, "R4 left byte 15");
    // R5 right byte raw 0 -> effective 15
    apply(mk(1, 2'd0, 5'd7, 5'd8, 5'd9), 128'd0, 64'h5A, 64'd0, "R5 right byte raw0");
    chk("R5 literal", vec_out, 128'h5A);
    // R6 halfword, word, doubleword at the last legal positions
    apply(mk(0, 2'd1, 5'd2, 5'd2, 5'd2), base, 64'hFFFF_0000_0000_BEEF, 64'd14, "R6 half at 14");
    apply(mk(0, 2'd2, 5'd2, 5'd2, 5'd2), base, 64'h0123_4567_89AB_CDEF, 64'd12, "R6 word at 12");
    apply(mk(0, 2'd3, 5'd2, 5'd2, 5'd2), base, 64'h0123_4567_89AB_CDEF, 64'd8, "R6 dword at 8");
    chk("R7 literal", vec_out, 128'h00112233_44556677_01234567_89ABCDEF);
    // R8 out of range in left mode, one past the limit
    apply(mk(0, 2'd1, 5'd2, 5'd2, 5'd2), base, 64'h1234, 64'd15, "R8 half at 15");
    apply(mk(0, 2'd2, 5'd2, 5'd2, 5'd2), base, 64'h1234, 64'd13, "R8 word at 13");
    apply(mk(0, 2'd3, 5'd2, 5'd2, 5'd2), base, 64'h1234, 64'd9, "R8 dword at 9");
    // R5/R8 right mode: raw 8 -> 0 legal, raw 9 -> -1 rejected
    apply(mk(1, 2'd3, 5'd6, 5'd6, 5'd6), base, 64'hCAFEF00D_DEADBEEF, 64'd8, "R5 right dword raw8");
    apply(mk(1, 2'd3, 5'd6, 5'd6, 5'd6), base, 64'hCAFEF00D_DEADBEEF, 64'd9, "R8 right dword raw9");
    idle(2);
    // R3 upper index bits ignored
    apply(mk(0, 2'd0, 5'd4, 5'd4, 5'd4), base, 64'h77, 64'hFFFF_FFFF_FFFF_FFF3, "R3 high bits");
    chk("R3 literal", vec_out, base ^ (128'h00 ^ {24'd0, 8'h33 ^ 8'h77, 96'd0}));
    // R1/R9 illegal encodings
    apply({6'b000101, 26'h0_0000_0F} | 32'h0000_020F, base, 64'h1, 64'd0, "R9 bad primary");
    apply(32'h1000_040F, base, 64'h1, 64'd0, "R1 bad xo head");
    apply(mk(0, 2'd0, 5'd1, 5'd1, 5'd1) ^ 32'h1, base, 64'h1, 64'd0, "R1 bad xo tail");
    idle(2);
    // Back-to-back mix, then random sweep checked against the model
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ins;
      ins = mk(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      if ((i % 17) == 0) ins = ins ^ (32'h1 << ($urandom % 32));
      apply(ins, {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, "R7 random");
      if ((i % 23) == 0) idle(1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule